// File: doc/BRIEF.md
# Lockable Board System Control Registers

This block is a small memory-mapped register page for board-level control. Software reads a fixed identity word and drives a bank of indicator lamps. It keeps two scratch configuration words and two flag words that are changed through separate set and clear addresses. It can also ask the board to reset. The reset-control register is guarded by a 16-bit key. Software must first write the key to the lock register, and only then does a write to reset control take effect.

The bus is a simple single-cycle register port with an address, a write strobe, write data and combinational read data. Two active-low asynchronous resets feed the block, and each is released synchronously inside it. The power-on reset clears everything. The system reset clears everything except the non-volatile flag word, so those flags survive a board reset that the block itself requested.

Top module: `board_ctrl_regs`

## Requirements
- R1: Byte offset 0x00 reads the identity constant (default 0x41007004). Writes to it change nothing.
- R2: Offset 0x08 is read/write and keeps the low LED_W (8) bits of the written data. The `led` output always equals this register.
- R3: Offset 0x20 holds a 16-bit lock value. Writing the full 32-bit value 0x0000A05F stores 0xA05F, which opens the lock. Any other write stores the low 16 bits of the data with bit 15 forced to 0, which closes the lock. A read returns the stored value zero-extended.
- R4: Offset 0x40 (reset control) takes the write data only while the lock holds 0xA05F. While the lock is closed the write is dropped. A read returns the last accepted value.
- R5: An accepted write to offset 0x40 with data bit 8 set drives `board_rst_req` high for exactly the one cycle that follows the write edge. A dropped write never raises it.
- R6: A write to offset 0x30 ORs the data into the flag word. A write to 0x34 clears the flag bits that are 1 in the data. Reading 0x30 returns the flag word, and reading 0x34 returns 0.
- R7: The non-volatile flag word works the same way: set at 0x38, clear at 0x3C, read at 0x38. Reading 0x3C returns 0.
- R8: Offsets 0x28 and 0x2C are independent 32-bit read/write registers.
- R9: Offset 0x44 always reads 1 and offset 0x50 always reads 0x1000, and writes to either change nothing. Every other offset, including any address with bits above bit 7 set, reads 0 and ignores writes. Address bits 1:0 are ignored.
- R10: Asserting `rst_n` clears every register except the non-volatile flags. Asserting `por_n` clears every register including them.
- R11: After either reset is released, every register reads 0, `led` is 0, `board_rst_req` is low and the lock is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| addr | input | ADDR_W (12) | Byte address within the page |
| wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| led | output | LED_W (8) | LED register value |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
A wrong lock state appears on the next read of offset 0x20. It also shows up as reset-control readback at 0x40 that either moved when it should have stayed or stayed when it should have moved, one edge after the write. A wrongly decoded address shows as a register that changed when a different offset was written, or as a constant offset that stopped reading its fixed value. Faults in the reset-request path are visible on `board_rst_req` exactly one cycle after the write edge. Faults in the reset domains appear as non-volatile flags that were lost, or kept, a few cycles after a reset is released.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
  // byte offsets inside the page (bits 7:0 of the address)
  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_LED    = 8'h08;
  localparam logic [7:0] OFF_LOCK   = 8'h20;
  localparam logic [7:0] OFF_CFG0   = 8'h28;
  localparam logic [7:0] OFF_CFG1   = 8'h2C;
  localparam logic [7:0] OFF_FSET   = 8'h30;
  localparam logic [7:0] OFF_FCLR   = 8'h34;
  localparam logic [7:0] OFF_NVSET  = 8'h38;
  localparam logic [7:0] OFF_NVCLR  = 8'h3C;
  localparam logic [7:0] OFF_RSTCTL = 8'h40;
  localparam logic [7:0] OFF_PCISTA = 8'h44;
  localparam logic [7:0] OFF_LCDSTA = 8'h50;
  localparam logic [15:0] DEF_KEY   = 16'hA05F;
endpackage

// File: rtl/board_ctrl_rstsync.sv
module board_ctrl_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/board_ctrl_setclr.sv
module board_ctrl_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = set_en | clr_en;
    q_d  = q;
    if (set_en)      q_d = q | din;
    else if (clr_en) q_d = q & ~din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((q & $past(din)) == $past(din))); // R6
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(din)) == '0)); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q)); // R6
endmodule

// File: rtl/board_ctrl_lock.sv
module board_ctrl_lock #(
  parameter int          W      = 16,
  parameter int          DATA_W = 32,
  parameter logic [15:0] KEY    = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic [W-1:0]      q,
  output logic              open
);
  localparam logic [W-1:0]      KEY_W   = W'(KEY);
  localparam logic [DATA_W-1:0] KEY_BUS = DATA_W'(KEY);
  localparam logic [W-1:0]      TOP_CLR = ~(W'(1) << (W-1));

  logic [W-1:0] q_d;

  always_comb begin
    if (din == KEY_BUS) q_d = KEY_W;
    else                q_d = din[W-1:0] & TOP_CLR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end

  assign open = (q == KEY_W);

  AST_LOCK_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (q != KEY_W) |-> !q[W-1]); // R3
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && din == KEY_BUS) |=> open); // R3
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          LED_W    = 8,
  parameter int          LOCK_W   = 16,
  parameter int          RST_BIT  = 8,
  parameter int          SYNC_STG = 2,
  parameter logic [31:0] ID_WORD  = 32'h4100_7004,
  parameter logic [15:0] KEY      = DEF_KEY,
  parameter logic [31:0] PCI_STAT = 32'h0000_0001,
  parameter logic [31:0] LCD_STAT = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [LED_W-1:0]  led,
  output logic              board_rst_req
);
  localparam int DW = 32;

  logic sys_srst_n, por_srst_n, sys_arst_n;
  logic in_page;
  logic [7:0] off;
  logic we_led, we_lock, we_cfg0, we_cfg1, we_fset, we_fclr;
  logic we_nvset, we_nvclr, we_rstctl;
  logic [LED_W-1:0]  led_q, led_d;
  logic [DW-1:0]     cfg0_q, cfg0_d, cfg1_q, cfg1_d, rstctl_q, rstctl_d;
  logic [DW-1:0]     flags_q, nvflags_q;
  logic [LOCK_W-1:0] lock_q;
  logic              lock_open;
  logic              req_q, req_d, rstctl_en;

  assign sys_arst_n = por_n & rst_n;

  board_ctrl_rstsync #(.STAGES(SYNC_STG)) u_sync_sys (
    .clk(clk), .arst_n(sys_arst_n), .srst_n(sys_srst_n));
  board_ctrl_rstsync #(.STAGES(SYNC_STG)) u_sync_por (
    .clk(clk), .arst_n(por_n), .srst_n(por_srst_n));

  // address decode
  always_comb begin
    in_page   = (addr >> 8) == '0;
    off       = {addr[7:2], 2'b00};
    we_led    = wr_en && in_page && off == OFF_LED;
    we_lock   = wr_en && in_page && off == OFF_LOCK;
    we_cfg0   = wr_en && in_page && off == OFF_CFG0;
    we_cfg1   = wr_en && in_page && off == OFF_CFG1;
    we_fset   = wr_en && in_page && off == OFF_FSET;
    we_fclr   = wr_en && in_page && off == OFF_FCLR;
    we_nvset  = wr_en && in_page && off == OFF_NVSET;
    we_nvclr  = wr_en && in_page && off == OFF_NVCLR;
    we_rstctl = wr_en && in_page && off == OFF_RSTCTL;
  end

  board_ctrl_lock #(.W(LOCK_W), .DATA_W(DW), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(sys_srst_n), .wr_en(we_lock), .din(wr_data),
    .q(lock_q), .open(lock_open));

  board_ctrl_setclr #(.W(DW)) u_flags (
    .clk(clk), .rst_n(sys_srst_n), .set_en(we_fset), .clr_en(we_fclr),
    .din(wr_data), .q(flags_q));

  board_ctrl_setclr #(.W(DW)) u_nvflags (
    .clk(clk), .rst_n(por_srst_n), .set_en(we_nvset), .clr_en(we_nvclr),
    .din(wr_data), .q(nvflags_q));

  // next state for plain registers
  always_comb begin
    led_d     = wr_data[LED_W-1:0];
    cfg0_d    = wr_data;
    cfg1_d    = wr_data;
    rstctl_en = we_rstctl && lock_open;
    rstctl_d  = wr_data;
    req_d     = rstctl_en && wr_data[RST_BIT];
  end

  always_ff @(posedge clk or negedge sys_srst_n) begin
    if (!sys_srst_n) begin
      led_q    <= '0;
      cfg0_q   <= '0;
      cfg1_q   <= '0;
      rstctl_q <= '0;
      req_q    <= 1'b0;
    end else begin
      if (we_led)    led_q    <= led_d;
      if (we_cfg0)   cfg0_q   <= cfg0_d;
      if (we_cfg1)   cfg1_q   <= cfg1_d;
      if (rstctl_en) rstctl_q <= rstctl_d;
      req_q <= req_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (in_page) begin
      case (off)
        OFF_ID:     rd_data = ID_WORD;
        OFF_LED:    rd_data = DW'(led_q);
        OFF_LOCK:   rd_data = DW'(lock_q);
        OFF_CFG0:   rd_data = cfg0_q;
        OFF_CFG1:   rd_data = cfg1_q;
        OFF_FSET:   rd_data = flags_q;
        OFF_NVSET:  rd_data = nvflags_q;
        OFF_RSTCTL: rd_data = rstctl_q;
        OFF_PCISTA: rd_data = PCI_STAT;
        OFF_LCDSTA: rd_data = LCD_STAT;
        default:    rd_data = '0;
      endcase
    end
  end

  assign led           = led_q;
  assign board_rst_req = req_q;

  AST_RSTCTL_GUARD: assert property (@(posedge clk) disable iff (!sys_srst_n)
    !lock_open |=> $stable(rstctl_q)); // R4
  AST_REQ_BIT: assert property (@(posedge clk) disable iff (!sys_srst_n)
    board_rst_req |-> rstctl_q[RST_BIT]); // R5
  AST_REQ_OPEN: assert property (@(posedge clk) disable iff (!sys_srst_n)
    board_rst_req |-> $past(lock_open)); // R5
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!sys_srst_n)
    (addr == '0) |-> (rd_data == ID_WORD)); // R1
endmodule

// File: tb/board_ctrl_regs_test.sv
module board_ctrl_regs_test;
  localparam int AW = 12;
  localparam int VW = 1 + AW + 32 + 32 + 4;
  localparam int NV = 30;

  logic clk = 1'b0;
  logic por_n, rst_n, wr_en;
  logic [AW-1:0] addr;
  logic [31:0] wr_data, rd_data;
  logic [7:0] led;
  logic board_rst_req;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  board_ctrl_regs uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .led(led),
    .board_rst_req(board_rst_req));

  // {write, address, write data, expected read, requirement}
  localparam logic [VW-1:0] TBL [0:NV-1] = '{
    {1'b0, 12'h000, 32'h0, 32'h4100_7004, 4'd1},
    {1'b1, 12'h000, 32'hDEAD_BEEF, 32'h0, 4'd1},
    {1'b0, 12'h000, 32'h0, 32'h4100_7004, 4'd1},
    {1'b1, 12'h008, 32'h1234_56A5, 32'h0, 4'd2},
    {1'b0, 12'h008, 32'h0, 32'h0000_00A5, 4'd2},
    {1'b1, 12'h028, 32'h1234_5678, 32'h0, 4'd8},
    {1'b1, 12'h02C, 32'hCAFE_F00D, 32'h0, 4'd8},
    {1'b0, 12'h028, 32'h0, 32'h1234_5678, 4'd8},
    {1'b0, 12'h02E, 32'h0, 32'hCAFE_F00D, 4'd8},
    {1'b1, 12'h030, 32'h0000_00F0, 32'h0, 4'd6},
    {1'b1, 12'h030, 32'h0000_0F00, 32'h0, 4'd6},
    {1'b0, 12'h030, 32'h0, 32'h0000_0FF0, 4'd6},
    {1'b1, 12'h034, 32'h0000_0330, 32'h0, 4'd6},
    {1'b0, 12'h030, 32'h0, 32'h0000_0CC0, 4'd6},
    {1'b0, 12'h034, 32'h0, 32'h0, 4'd6},
    {1'b1, 12'h038, 32'h0000_0081, 32'h0, 4'd7},
    {1'b1, 12'h03C, 32'h0000_0001, 32'h0, 4'd7},
    {1'b0, 12'h038, 32'h0, 32'h0000_0080, 4'd7},
    {1'b0, 12'h044, 32'h0, 32'h0000_0001, 4'd9},
    {1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0, 4'd9},
    {1'b0, 12'h050, 32'h0, 32'h0000_1000, 4'd9},
    {1'b1, 12'h128, 32'h5555_5555, 32'h0, 4'd9},
    {1'b0, 12'h028, 32'h0, 32'h1234_5678, 4'd9},
    {1'b0, 12'h128, 32'h0, 32'h0, 4'd9},
    {1'b1, 12'h020, 32'h0000_FFFF, 32'h0, 4'd3},
    {1'b0, 12'h020, 32'h0, 32'h0000_7FFF, 4'd3},
    {1'b1, 12'h040, 32'h0000_0055, 32'h0, 4'd4},
    {1'b0, 12'h040, 32'h0, 32'h0, 4'd4},
    {1'b1, 12'h020, 32'h0000_A05F, 32'h0, 4'd3},
    {1'b0, 12'h020, 32'h0, 32'h0000_A05F, 4'd3}
  };

  function automatic string rtag(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 check(rd_data, exp, tag);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    wait_cyc(3);
    por_n = 1'b1; rst_n = 1'b1;
    wait_cyc(4);
    // R11 reset state
    #1 check(32'(led), 32'h0, "R11 led");
    check(32'(board_rst_req), 32'h0, "R11 req");
    rd_chk(12'h008, 32'h0, "R11 led reg");
    rd_chk(12'h020, 32'h0, "R11 lock");
    rd_chk(12'h038, 32'h0, "R11 nvflags");

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = TBL[i];
      @(negedge clk);
      addr = v[VW-2 -: AW];
      wr_data = v[67:36];
      wr_en = v[VW-1];
      if (!v[VW-1]) #1 check(rd_data, v[35:4], rtag(int'(v[3:0])));
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R2 led output
    #1 check(32'(led), 32'h0000_00A5, "R2 led port");

    // R4 unlocked write lands, R5 pulse timing
    @(negedge clk);
    addr = 12'h040; wr_data = 32'h0000_0100; wr_en = 1'b1;
    #1 check(32'(board_rst_req), 32'h0, "R5 before edge");
    @(negedge clk);
    wr_en = 1'b0;
    #1 check(32'(board_rst_req), 32'h1, "R5 pulse high");
    @(negedge clk);
    #1 check(32'(board_rst_req), 32'h0, "R5 pulse ends");
    rd_chk(12'h040, 32'h0000_0100, "R4 readback");

    // R3 near-key value closes lock; R5 dropped write makes no pulse
    wr(12'h020, 32'h0001_A05F);
    rd_chk(12'h020, 32'h0000_205F, "R3 near key");
    @(negedge clk);
    addr = 12'h040; wr_data = 32'h0000_01FF; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1 check(32'(board_rst_req), 32'h0, "R5 locked no pulse");
    rd_chk(12'h040, 32'h0000_0100, "R4 locked hold");

    // R10 system reset keeps nv flags
    wr(12'h038, 32'h0000_0005);
    wr(12'h030, 32'h0000_0003);
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(2); rst_n = 1'b1;
    wait_cyc(4);
    rd_chk(12'h038, 32'h0000_0085, "R10 nv kept");
    rd_chk(12'h030, 32'h0, "R10 flags cleared");
    rd_chk(12'h028, 32'h0, "R10 cfg cleared");
    rd_chk(12'h040, 32'h0, "R10 rstctl cleared");
    #1 check(32'(led), 32'h0, "R10 led cleared");

    // R10 power-on reset clears nv flags
    @(negedge clk); por_n = 1'b0;
    wait_cyc(2); por_n = 1'b1;
    wait_cyc(4);
    rd_chk(12'h038, 32'h0, "R10 nv por");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule